// File: doc/BRIEF.md
# Three-Level Nested Vectored Interrupt Arbiter

This block picks which interrupt the processor takes next. Ten vector slots each collect a group of interrupt sources. If any source in a slot is asserted, the slot is pending. Each slot also carries a programmable priority of low, high or highest.

The arbiter compares every pending slot against the level that is currently in service. It then presents a single request to the core, together with the winning vector address and the level that would be entered. Requests at or below the level in service are held back.

A small internal stack records nesting. When the core acknowledges a request, the accepted level becomes the new in-service level. A return from interrupt restores the level that was active before. All outputs are combinational from the inputs and the stack, so a change to the stack shows up on the outputs in the cycle right after the acknowledge or return edge.

Top module: `vec_irq_arbiter`

## Requirements
- R1: While reset is held, and after it is released with no source asserted, `irq` is 0, `vec_addr` is 0, `acc_level` is 0 and `svc_level` is 0 (nothing in service). Reset is synchronous and active low.
- R2: Source bit `v*SRC_PER_SLOT + s` of `src_req` belongs to slot `v`. A slot is pending when any one of its source bits is 1.
- R3: Slot `v` takes its 2-bit level code from `slot_level[2v+1:2v]`. Code 0 is low (rank 1), code 1 is high (rank 2), and codes 2 and 3 are both highest (rank 3).
- R4: A pending slot is eligible only if its rank is strictly greater than `svc_level`. `svc_level` is 0 when nothing is in service, 1 for low, 2 for high and 3 for highest. Nested in-service levels always increase strictly from the bottom of the stack to the top.
- R5: Among eligible slots, the one with the greatest rank wins.
- R6: Among eligible slots of equal greatest rank, the lowest slot index wins, and exactly one slot is granted.
- R7: While `irq` is 1, `vec_addr` equals 0x00003 + 8 × winning index and `acc_level` equals the winner's rank. While `irq` is 0, both are 0.
- R8: While `glb_en` is 0, `irq` is 0 whatever the pending requests are.
- R9: An `ack` at a clock edge where `irq` is 1 and `reti` is 0 pushes `acc_level`, so `svc_level` equals that level after the edge. An `ack` while `irq` is 0 leaves `svc_level` unchanged. The stack never overflows.
- R10: A `reti` pops the stack, so `svc_level` returns to the level that was in service before. A `reti` with nothing in service is ignored. When `reti` and `ack` arrive in the same cycle, the pop happens and the `ack` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_req | input | NUM_VEC*SRC_PER_SLOT | Interrupt source lines, grouped by slot |
| slot_level | input | 2*NUM_VEC | Per-slot priority level codes |
| glb_en | input | 1 | Global interrupt enable |
| ack | input | 1 | Core accepts the presented interrupt |
| reti | input | 1 | Core returns from the current interrupt |
| irq | output | 1 | An eligible request is being presented |
| vec_addr | output | ADDR_W | Vector address of the winner |
| acc_level | output | 2 | Rank the winner would enter (0 when no request) |
| svc_level | output | 2 | Rank currently in service (0 when none) |

## Verification
The bench sweeps every slot, source and level code on its own. It then sweeps randomized masks with random and with uniform levels, comparing each result against an arithmetic model at every nesting depth.

- A selector that breaks ties toward the higher index, or that lets an equal level through, would present the wrong address. It would also show a request while an equal level is in service.
- A stack that pops on an empty return, or that honours an acknowledge while no request is shown, would leave a wrong `svc_level`. Such a fault masks or unmasks later requests.
- Giving the acknowledge priority over a simultaneous return would push instead of pop. The bench hits exactly this collision.

// File: rtl/irq_arb_pkg.sv
// Package: shared types and the level-code to rank mapping for the
// interrupt arbiter. Assumes 2-bit level codes and 2-bit ranks.
package irq_arb_pkg;

    // Rank: 0 = nothing, 1 = low, 2 = high, 3 = highest
    typedef logic [1:0] rank_t;

    // Map a programmed level code to its rank; codes 2 and 3 are both highest
    function automatic rank_t code_to_rank(input logic [1:0] code);
        rank_t r;
        case (code)
            2'd0:    r = 2'd1;
            2'd1:    r = 2'd2;
            default: r = 2'd3;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/irq_src_merge.sv
// Module: irq_src_merge
// ORs the group of source lines belonging to each vector slot into one
// pending bit. Assumes sources are packed slot-major, SRC_PER_SLOT per slot.
module irq_src_merge #(
    parameter int NUM_VEC      = 10,
    parameter int SRC_PER_SLOT = 3
) (
    input  logic [NUM_VEC*SRC_PER_SLOT-1:0] src_req,
    output logic [NUM_VEC-1:0]              slot_pend
);

    // One reduction OR per slot
    for (genvar v = 0; v < NUM_VEC; v++) begin : g_slot
        assign slot_pend[v] = |src_req[v*SRC_PER_SLOT +: SRC_PER_SLOT];
    end

endmodule

// File: rtl/irq_prio_select.sv
// Module: irq_prio_select
// Chooses among pending slots the one with the greatest rank strictly above
// the in-service rank; ties go to the lowest index. Purely combinational.
// Assumes ranks are nonzero for every slot (all codes map to rank >= 1).
module irq_prio_select
    import irq_arb_pkg::*;
#(
    parameter int NUM_VEC = 10,
    localparam int IDX_W  = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
    input  logic [NUM_VEC-1:0]   slot_pend,
    input  logic [2*NUM_VEC-1:0] slot_level,
    input  rank_t                svc_rank,
    output logic                 any_win,
    output logic [IDX_W-1:0]     win_idx,
    output rank_t                win_rank,
    output logic [NUM_VEC-1:0]   grant
);

    rank_t              slot_rank [NUM_VEC];
    logic [NUM_VEC-1:0] elig;

    // Per-slot rank decode and eligibility against the in-service rank
    for (genvar v = 0; v < NUM_VEC; v++) begin : g_rank
        assign slot_rank[v] = code_to_rank(slot_level[2*v +: 2]);
        assign elig[v]      = slot_pend[v] && (slot_rank[v] > svc_rank);
    end

    // Scan from the top index down so that an equal rank at a lower index replaces it
    always_comb begin
        win_idx  = '0;
        win_rank = '0;
        for (int i = NUM_VEC - 1; i >= 0; i--) begin
            if (elig[i] && (slot_rank[i] >= win_rank)) begin
                win_idx  = IDX_W'(i);
                win_rank = slot_rank[i];
            end
        end
    end

    // One-hot grant and presence flag derived from the scan result
    always_comb begin
        any_win = (win_rank != 2'd0);
        grant   = '0;
        if (any_win) grant[win_idx] = 1'b1;
    end

endmodule

// File: rtl/irq_level_stack.sv
// Module: irq_level_stack
// Shift stack of in-service ranks; entry 0 is the top. A push shifts down,
// a pop shifts up and fills with zero. Pop wins over push. Assumes pushed
// ranks are nonzero and strictly above the current top (enforced upstream).
module irq_level_stack
    import irq_arb_pkg::*;
#(
    parameter int DEPTH = 3,
    localparam int SP_W = $clog2(DEPTH + 1)
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  push,
    input  rank_t push_rank,
    input  logic  pop,
    output rank_t top_rank
);

    rank_t           stk [DEPTH];
    logic [SP_W-1:0] sp;
    logic            do_pop;
    logic            do_push;

    // Pop only when something is stacked; push only when no pop this cycle
    assign do_pop   = pop && (sp != '0);
    assign do_push  = push && !pop && (sp != SP_W'(DEPTH));
    assign top_rank = stk[0];

    // Occupancy counter
    always_ff @(posedge clk) begin
        if (!rst_n)       sp <= '0;
        else if (do_pop)  sp <= sp - 1'b1;
        else if (do_push) sp <= sp + 1'b1;
    end

    // Stack entries, one register per level of nesting
    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stk[i] <= '0;
            end else if (do_pop) begin
                if (i == DEPTH - 1) stk[i] <= '0;
                else                stk[i] <= stk[(i + 1) % DEPTH];
            end else if (do_push) begin
                if (i == 0) stk[i] <= push_rank;
                else        stk[i] <= stk[(i + DEPTH - 1) % DEPTH];
            end
        end
    end

    // R9: a push request never meets a full stack
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |-> (sp != SP_W'(DEPTH)));

    // R10: a pop exposes the entry that was beneath the top
    p_pop_restores_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && sp != '0) |=> (top_rank == $past(stk[(1 % DEPTH)]) || DEPTH == 1));

    // R10: a pop on an empty stack changes nothing
    p_empty_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && sp == '0) |=> (top_rank == 2'd0 && sp == '0));

    // R4: nested levels increase strictly toward the top
    p_nest_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sp >= SP_W'(2)) |-> (stk[0] > stk[(1 % DEPTH)]));

endmodule

// File: rtl/vec_irq_arbiter.sv
// Module: vec_irq_arbiter (top)
// Three-level nested vectored interrupt arbiter. Merges sources per slot,
// selects the winner above the in-service level, presents its vector
// address and level, and tracks nesting on acknowledge and return.
// Assumes the core raises ack only for the request it sees on irq.
module vec_irq_arbiter
    import irq_arb_pkg::*;
#(
    parameter int NUM_VEC      = 10,
    parameter int SRC_PER_SLOT = 3,
    parameter int ADDR_W       = 17,
    parameter int VEC_BASE     = 3,
    parameter int VEC_STRIDE   = 8,
    parameter int STK_DEPTH    = 3,
    localparam int IDX_W       = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1,
    localparam int LAST_ADDR   = VEC_BASE + VEC_STRIDE * (NUM_VEC - 1)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_VEC*SRC_PER_SLOT-1:0] src_req,
    input  logic [2*NUM_VEC-1:0]            slot_level,
    input  logic                            glb_en,
    input  logic                            ack,
    input  logic                            reti,
    output logic                            irq,
    output logic [ADDR_W-1:0]               vec_addr,
    output logic [1:0]                      acc_level,
    output logic [1:0]                      svc_level
);

    logic [NUM_VEC-1:0] slot_pend;
    logic [NUM_VEC-1:0] grant;
    logic               any_win;
    logic [IDX_W-1:0]   win_idx;
    rank_t              win_rank;
    rank_t              svc_rank;

    irq_src_merge #(
        .NUM_VEC      (NUM_VEC),
        .SRC_PER_SLOT (SRC_PER_SLOT)
    ) u_merge (
        .src_req   (src_req),
        .slot_pend (slot_pend)
    );

    irq_prio_select #(
        .NUM_VEC (NUM_VEC)
    ) u_select (
        .slot_pend  (slot_pend),
        .slot_level (slot_level),
        .svc_rank   (svc_rank),
        .any_win    (any_win),
        .win_idx    (win_idx),
        .win_rank   (win_rank),
        .grant      (grant)
    );

    irq_level_stack #(
        .DEPTH (STK_DEPTH)
    ) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (ack && irq),
        .push_rank (win_rank),
        .pop       (reti),
        .top_rank  (svc_rank)
    );

    // Outputs to the core: gated request, vector address and entry level
    always_comb begin
        irq       = glb_en && any_win;
        vec_addr  = '0;
        acc_level = '0;
        if (irq) begin
            vec_addr  = ADDR_W'(VEC_BASE) + ADDR_W'(win_idx) * ADDR_W'(VEC_STRIDE);
            acc_level = win_rank;
        end
        svc_level = svc_rank;
    end

    // R8: the global enable masks every request
    p_glb_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_en |-> !irq);

    // R4: a presented request lies strictly above the in-service level
    p_above_svc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (acc_level > svc_level));

    // R6: at most one slot is granted
    p_onehot_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R7: the address lands on a slot entry inside the vector range
    p_addr_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (int'(vec_addr) >= VEC_BASE && int'(vec_addr) <= LAST_ADDR &&
                 ((int'(vec_addr) - VEC_BASE) % VEC_STRIDE) == 0));

    // R9: an accepted acknowledge enters the presented level
    p_push_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq && !reti) |=> (svc_level == $past(acc_level)));

    // R9: an acknowledge with nothing presented leaves the level alone
    p_ack_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !irq && !reti) |=> $stable(svc_level));

endmodule

// File: tb/vec_irq_arbiter_tb_top.sv
`timescale 1ns/1ps
module vec_irq_arbiter_tb_top;

    localparam int NV = 10;
    localparam int SP = 3;
    localparam int AW = 17;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [NV*SP-1:0] src_req;
    logic [2*NV-1:0] slot_level;
    logic            glb_en;
    logic            ack;
    logic            reti;
    logic            irq;
    logic [AW-1:0]   vec_addr;
    logic [1:0]      acc_level;
    logic [1:0]      svc_level;

    int n_tests = 0;
    int n_fail  = 0;
    int m_stk[$];

    always #5 clk = ~clk;

    vec_irq_arbiter dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_req    (src_req),
        .slot_level (slot_level),
        .glb_en     (glb_en),
        .ack        (ack),
        .reti       (reti),
        .irq        (irq),
        .vec_addr   (vec_addr),
        .acc_level  (acc_level),
        .svc_level  (svc_level)
    );

    function automatic int m_svc();
        return (m_stk.size() > 0) ? m_stk[$] : 0;
    endfunction

    // Reference: strictly greater rank wins, ascending scan keeps the lowest index
    function automatic void model(input logic [NV*SP-1:0] s, input logic [2*NV-1:0] l,
                                  input logic en, input int svc,
                                  output logic e_irq, output int e_idx, output int e_rk);
        e_idx = 0;
        e_rk  = 0;
        for (int i = 0; i < NV; i++) begin
            int r;
            r = (l[2*i +: 2] == 2'd3) ? 3 : int'(l[2*i +: 2]) + 1;
            if ((|s[i*SP +: SP]) && r > svc && r > e_rk) begin
                e_idx = i;
                e_rk  = r;
            end
        end
        e_irq = en && (e_rk != 0);
        if (!e_irq) begin
            e_idx = 0;
            e_rk  = 0;
        end
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int got, input int exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, got, exp);
        end
    endtask

    // Compare all combinational outputs with the model
    task automatic chk_outs(input string req);
        logic e_irq;
        int   e_idx;
        int   e_rk;
        int   e_addr;
        model(src_req, slot_level, glb_en, m_svc(), e_irq, e_idx, e_rk);
        e_addr = e_irq ? 3 + 8 * e_idx : 0;
        n_tests++;
        if (irq !== e_irq || int'(vec_addr) != e_addr || int'(acc_level) != e_rk ||
            int'(svc_level) != m_svc()) begin
            n_fail++;
            $display("FAIL %s: actual irq=%0b addr=%0d lvl=%0d svc=%0d expected irq=%0b addr=%0d lvl=%0d svc=%0d",
                     req, irq, vec_addr, acc_level, svc_level, e_irq, e_addr, e_rk, m_svc());
        end
    endtask

    // Pulse ack and/or reti for one edge, update the model, check svc_level
    task automatic pulse(input logic a, input logic r, input string req);
        logic e_irq;
        int   e_idx;
        int   e_rk;
        model(src_req, slot_level, glb_en, m_svc(), e_irq, e_idx, e_rk);
        ack  = a;
        reti = r;
        tick();
        ack  = 1'b0;
        reti = 1'b0;
        if (r) begin
            if (m_stk.size() > 0) void'(m_stk.pop_back());
        end else if (a && e_irq) begin
            m_stk.push_back(e_rk);
        end
        chk(req, int'(svc_level), m_svc());
    endtask

    task automatic rand_sweep(input int n, input string req);
        for (int k = 0; k < n; k++) begin
            src_req = NV*SP'({$urandom, $urandom});
            if (k % 3 == 1) src_req = src_req & NV*SP'($urandom);
            if (k % 3 == 2) src_req = src_req & NV*SP'($urandom) & NV*SP'($urandom);
            slot_level = 2*NV'($urandom);
            #1;
            chk_outs(req);
        end
    endtask

    initial begin
        #2_000_000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; src_req = '0; slot_level = '0; glb_en = 1'b1; ack = 1'b0; reti = 1'b0;
        repeat (3) tick();
        // R1: reset state, during and after reset
        chk("R1 irq in reset", int'(irq), 0);
        chk("R1 svc in reset", int'(svc_level), 0);
        rst_n = 1'b1;
        tick();
        chk("R1 irq after reset", int'(irq), 0);
        chk("R1 addr after reset", int'(vec_addr), 0);
        chk("R1 level after reset", int'(acc_level), 0);
        chk("R1 svc after reset", int'(svc_level), 0);

        // R2 R3 R7: every slot, every source, every level code on its own
        for (int v = 0; v < NV; v++) begin
            for (int s = 0; s < SP; s++) begin
                for (int c = 0; c < 4; c++) begin
                    src_req = '0;
                    src_req[v*SP + s] = 1'b1;
                    slot_level = 2*NV'($urandom);
                    slot_level[2*v +: 2] = 2'(c);
                    #1;
                    chk("R2 slot pending", int'(irq), 1);
                    chk("R7 vector address", int'(vec_addr), 3 + 8 * v);
                    chk("R3 level rank", int'(acc_level), (c == 3) ? 3 : c + 1);
                end
            end
        end

        // R5 R6: mixed masks, random levels, nothing in service
        rand_sweep(400, "R5 highest level wins");
        // R6: uniform levels so only the index decides
        for (int k = 0; k < 60; k++) begin
            src_req = NV*SP'({$urandom, $urandom}) & NV*SP'($urandom);
            slot_level = {NV{2'(k % 4)}};
            #1;
            chk_outs("R6 lowest index tie");
        end

        // R8: enable low masks everything
        glb_en = 1'b0;
        rand_sweep(50, "R8 enable mask");
        glb_en = 1'b1;

        // R9: ack with no request is ignored
        src_req = '0;
        #1;
        pulse(1'b1, 1'b0, "R9 ack idle ignored");
        // R10: return with nothing in service is ignored
        pulse(1'b0, 1'b1, "R10 empty return ignored");

        // R9: enter low at slot 4
        src_req = '0; src_req[4*SP] = 1'b1; slot_level = '0;
        #1;
        pulse(1'b1, 1'b0, "R9 push low");
        rand_sweep(100, "R4 above low only");
        // Equal level in service blocks a same-level request
        src_req = '0; src_req[0] = 1'b1; slot_level = '0;
        #1;
        chk("R4 equal level blocked", int'(irq), 0);

        // R9: enter high at slot 7
        src_req = '0; src_req[7*SP + 2] = 1'b1; slot_level = '0; slot_level[15:14] = 2'd1;
        #1;
        pulse(1'b1, 1'b0, "R9 push high");
        rand_sweep(100, "R4 above high only");

        // R9: enter highest at slot 9
        src_req = '0; src_req[9*SP + 1] = 1'b1; slot_level = '0; slot_level[19:18] = 2'd2;
        #1;
        pulse(1'b1, 1'b0, "R9 push highest");
        rand_sweep(50, "R4 nothing above highest");
        src_req = '1; slot_level = '1;
        #1;
        pulse(1'b1, 1'b0, "R9 ack blocked at highest");

        // R10: unwind restores each previous level
        src_req = '0;
        #1;
        pulse(1'b0, 1'b1, "R10 pop to high");
        rand_sweep(30, "R4 after pop to high");
        src_req = '0;
        #1;
        pulse(1'b0, 1'b1, "R10 pop to low");
        src_req = '0;
        #1;
        pulse(1'b0, 1'b1, "R10 pop to none");
        pulse(1'b0, 1'b1, "R10 extra pop ignored");

        // R10: return and acknowledge together: the pop wins
        src_req = '0; src_req[2*SP] = 1'b1; slot_level = '0;
        #1;
        pulse(1'b1, 1'b0, "R9 push low again");
        src_req = '0; src_req[5*SP] = 1'b1; slot_level = '0; slot_level[11:10] = 2'd1;
        #1;
        chk("R4 high above low presented", int'(irq), 1);
        pulse(1'b1, 1'b1, "R10 return beats ack");
        chk_outs("R10 outputs after collision");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule